// File: doc/BRIEF.md
# Stepped Gate-Drive Fault Sequencer

This clocked controller decides the drive level of a single isolated power-switch gate. A qualified on-command does not drive the gate fully high at once. It first selects an intermediate clamp plateau for a programmable number of cycles and then selects full drive. The desaturation flag from an external comparator is ignored for a blanking window that starts at the on-request.

Once the window has closed, a desaturation event pulls the gate back to the plateau for a programmable fault time and asserts a fault reply flag. What follows depends on the flag on the last cycle of that time. If the event has cleared, the gate returns to full drive. If it persists, the gate is forced off and held in a lockout that refuses on-commands for a programmable time.

The enable input is active low. Deasserting it, or raising the undervoltage flag, forces the gate off. All durations are parameters counted in clock cycles.

Top module: `gsq_top`

## Requirements
- R1: After reset, `drive_o` is off (2'b00) and `fault_o` is low.
- R2: The command is qualified when `cmd_i`=1, `en_n_i`=0 and `uv_i`=0. When the qualified command rises, `drive_o` shows the clamp code 2'b01 for exactly PLATEAU_CYC cycles, starting on the next cycle. It then shows the full code 2'b10.
- R3: The desaturation flag passes through a two-flop synchronizer, so a change on `desat_i` acts on `drive_o` three clock edges later. The flag is ignored during the PLATEAU_CYC cycles of the plateau and the BLANK_EXTRA_CYC cycles that follow.
- R4: A synchronized desaturation seen at full drive after blanking selects clamp (2'b01) and sets `fault_o`=1 for FAULT_CYC cycles.
- R5: If the synchronized flag is low on the last fault cycle, `drive_o` returns to full and `fault_o` clears. No new blanking window starts.
- R6: If the synchronized flag is still high on the last fault cycle, `drive_o` goes off with `fault_o`=1 for LOCKOUT_CYC cycles. Command, enable and undervoltage changes do not shorten this lockout. At its end, `fault_o` clears.
- R7: After a lockout, a command held high does not restart the sequence. A new rising edge of the qualified command is needed, and rises that occur during the lockout are discarded.
- R8: `en_n_i`=1 or `uv_i`=1 makes `drive_o` off on the next cycle. This cancels a plateau or fault time in progress and clears `fault_o`, except during a lockout.
- R9: `cmd_i` falling during the plateau, full drive or fault time makes `drive_o` off on the next cycle, with `fault_o` low.
- R10: `drive_o` never carries the code 2'b11, and `fault_o` is never high while `drive_o` is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 1 | Gate on-command |
| en_n_i | input | 1 | Active-low enable |
| uv_i | input | 1 | Undervoltage flag |
| desat_i | input | 1 | Asynchronous desaturation comparator flag |
| drive_o | output | 2 | Drive level: 00 off, 01 clamp, 10 full |
| fault_o | output | 1 | Fault reply flag (high = reply open) |

## Verification
Changes on the command, enable and undervoltage inputs show on `drive_o` one clock edge after they are sampled. Changes on `desat_i` need three edges because of the synchronizer. Plateau, blanking, fault and lockout lengths run from the edge that enters each phase. The bench drives inputs on falling edges. On each falling edge it compares both outputs with a cycle-level reference model of the requirements, and that model has the same one-edge and three-edge latencies. This keeps every expected value aligned with the cycle in which it becomes due. Directed scenarios place desaturation pulses inside and just outside the blanking window, and on either side of the last fault cycle.

// File: rtl/gsq_pkg.sv
package gsq_pkg;

    typedef enum logic [1:0] {
        DRV_OFF   = 2'b00,
        DRV_CLAMP = 2'b01,
        DRV_FULL  = 2'b10
    } drv_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PLAT,
        ST_ON,
        ST_FAULT,
        ST_LOCK
    } st_e;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/gsq_sync.sv
module gsq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] pipe_d, pipe_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb pipe_d = async_i;
        end else begin : g_many
            always_comb pipe_d = {pipe_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/gsq_cmd_qual.sv
module gsq_cmd_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_i,
    input  logic en_n_i,
    input  logic uv_i,
    output logic ok_o,
    output logic rise_o
);

    logic prev_d, prev_q;

    always_comb begin
        ok_o   = cmd_i & ~en_n_i & ~uv_i;
        rise_o = ok_o & ~prev_q;
        prev_d = ok_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/gsq_fsm.sv
module gsq_fsm
    import gsq_pkg::*;
#(
    parameter int PLATEAU_CYC     = 4,
    parameter int BLANK_EXTRA_CYC = 6,
    parameter int FAULT_CYC       = 5,
    parameter int LOCKOUT_CYC     = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ok_i,
    input  logic       rise_i,
    input  logic       desat_i,
    output logic [1:0] drive_o,
    output logic       fault_o
);

    localparam int MAXC = max_of4(PLATEAU_CYC, BLANK_EXTRA_CYC, FAULT_CYC, LOCKOUT_CYC);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] TP_LAST = CW'(PLATEAU_CYC - 1);
    localparam logic [CW-1:0] BX_END  = CW'(BLANK_EXTRA_CYC);
    localparam logic [CW-1:0] TF_LAST = CW'(FAULT_CYC - 1);
    localparam logic [CW-1:0] TD_LAST = CW'(LOCKOUT_CYC - 1);

    typedef struct packed {
        st_e           st;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t r_d, r_q;
    logic blank_done;

    always_comb begin
        r_d        = r_q;
        blank_done = (r_q.cnt >= BX_END);
        case (r_q.st)
            ST_OFF: begin
                if (rise_i) begin
                    r_d.st  = ST_PLAT;
                    r_d.cnt = '0;
                end
            end
            ST_PLAT: begin
                if (!ok_i) begin
                    r_d.st = ST_OFF;
                end else if (r_q.cnt == TP_LAST) begin
                    r_d.st  = ST_ON;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_ON: begin
                if (!ok_i) begin
                    r_d.st = ST_OFF;
                end else if (blank_done && desat_i) begin
                    r_d.st  = ST_FAULT;
                    r_d.cnt = '0;
                end else if (!blank_done) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_FAULT: begin
                if (!ok_i) begin
                    r_d.st = ST_OFF;
                end else if (r_q.cnt == TF_LAST) begin
                    if (desat_i) begin
                        r_d.st  = ST_LOCK;
                        r_d.cnt = '0;
                    end else begin
                        r_d.st  = ST_ON;
                        r_d.cnt = BX_END;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_LOCK: begin
                if (r_q.cnt == TD_LAST) r_d.st = ST_OFF;
                else                    r_d.cnt = r_q.cnt + 1'b1;
            end
            default: r_d.st = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_OFF;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        drive_o = DRV_OFF;
        fault_o = 1'b0;
        case (r_q.st)
            ST_PLAT:  drive_o = DRV_CLAMP;
            ST_ON:    drive_o = DRV_FULL;
            ST_FAULT: begin drive_o = DRV_CLAMP; fault_o = 1'b1; end
            ST_LOCK:  fault_o = 1'b1;
            default:  drive_o = DRV_OFF;
        endcase
    end

    AST_DRIVE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o != 2'b11) else $error("illegal drive code"); // R10
    AST_REPLY_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> drive_o != DRV_FULL) else $error("reply with full drive"); // R10
    AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_i |=> drive_o == DRV_OFF) else $error("drive not off when unqualified"); // R8
    AST_NO_JUMP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o == DRV_OFF |=> drive_o != DRV_FULL) else $error("full without plateau"); // R2
    AST_LOCK_FROM_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOCK && $past(r_q.st) != ST_LOCK) |-> $past(r_q.st) == ST_FAULT)
        else $error("lockout entered without fault"); // R6
    AST_FAULT_NEEDS_DESAT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ON && r_d.st == ST_FAULT) |-> desat_i) else $error("fault without desat"); // R4

endmodule

// File: rtl/gsq_top.sv
module gsq_top #(
    parameter int PLATEAU_CYC     = 4,
    parameter int BLANK_EXTRA_CYC = 6,
    parameter int FAULT_CYC       = 5,
    parameter int LOCKOUT_CYC     = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_i,
    input  logic       en_n_i,
    input  logic       uv_i,
    input  logic       desat_i,
    output logic [1:0] drive_o,
    output logic       fault_o
);

    logic desat_s, ok, rise;

    gsq_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (desat_i),
        .sync_o  (desat_s)
    );

    gsq_cmd_qual u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd_i),
        .en_n_i (en_n_i),
        .uv_i   (uv_i),
        .ok_o   (ok),
        .rise_o (rise)
    );

    gsq_fsm #(
        .PLATEAU_CYC     (PLATEAU_CYC),
        .BLANK_EXTRA_CYC (BLANK_EXTRA_CYC),
        .FAULT_CYC       (FAULT_CYC),
        .LOCKOUT_CYC     (LOCKOUT_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ok_i    (ok),
        .rise_i  (rise),
        .desat_i (desat_s),
        .drive_o (drive_o),
        .fault_o (fault_o)
    );

endmodule

// File: tb/sim_gsq_top.sv
`timescale 1ns/1ps
module sim_gsq_top;

    localparam int TP = 4;
    localparam int BX = 6;
    localparam int TF = 5;
    localparam int TD = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd = 1'b0, en_n = 1'b0, uv = 1'b0, desat = 1'b0;
    logic [1:0] drive;
    logic fault;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    gsq_top #(.PLATEAU_CYC(TP), .BLANK_EXTRA_CYC(BX), .FAULT_CYC(TF), .LOCKOUT_CYC(TD)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .en_n_i(en_n), .uv_i(uv),
        .desat_i(desat), .drive_o(drive), .fault_o(fault)
    );

    // Reference model: 0 off, 1 plateau, 2 full, 3 fault time, 4 lockout
    int m_st = 0, m_cnt = 0;
    logic m_prev = 1'b0, m_s1 = 1'b0, m_s2 = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_prev = 1'b0; m_s1 = 1'b0; m_s2 = 1'b0;
        end else begin
            logic ok, rise;
            ok   = cmd & ~en_n & ~uv;
            rise = ok & ~m_prev;
            case (m_st)
                0: if (rise) begin m_st = 1; m_cnt = 0; end
                1: if (!ok) m_st = 0;
                   else if (m_cnt == TP-1) begin m_st = 2; m_cnt = 0; end
                   else m_cnt++;
                2: if (!ok) m_st = 0;
                   else if (m_cnt >= BX && m_s2) begin m_st = 3; m_cnt = 0; end
                   else if (m_cnt < BX) m_cnt++;
                3: if (!ok) m_st = 0;
                   else if (m_cnt == TF-1) begin
                       if (m_s2) begin m_st = 4; m_cnt = 0; end
                       else begin m_st = 2; m_cnt = BX; end
                   end else m_cnt++;
                default: if (m_cnt == TD-1) m_st = 0; else m_cnt++;
            endcase
            m_prev = ok;
            m_s2 = m_s1;
            m_s1 = desat;
        end
    end

    function automatic logic [1:0] exp_drive(input int st);
        case (st)
            1, 3:    return 2'b01;
            2:       return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic exp_fault(input int st);
        return (st == 3 || st == 4);
    endfunction

    task automatic tick();
        @(negedge clk);
        checks++;
        if (drive !== exp_drive(m_st) || fault !== exp_fault(m_st)) begin
            errors++;
            $display("FAIL %s t=%0t drive=%b fault=%b expected drive=%b fault=%b",
                     tag, $time, drive, fault, exp_drive(m_st), exp_fault(m_st));
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state
        tag = "R1";
        run(3);
        rst_n = 1'b1;
        run(2);

        // R2: plateau then full
        tag = "R2";
        cmd = 1'b1; run(TP + BX + 4);
        cmd = 1'b0; run(3);

        // R3: desat pulse inside blanking is ignored
        tag = "R3";
        cmd = 1'b1; run(1);
        desat = 1'b1; run(3);
        desat = 1'b0; run(TP + BX + 4);

        // R4 / R5: short desat after blanking, recovery without re-blanking
        tag = "R4";
        desat = 1'b1; run(2);
        desat = 1'b0; run(4);
        tag = "R5";
        run(TF + 2);
        desat = 1'b1; run(1);
        desat = 1'b0; run(TF + 5);

        // R6 / R7: persistent desat, lockout, held command, then new rise
        tag = "R6";
        desat = 1'b1; run(TF + 4);
        desat = 1'b0;
        cmd = 1'b0; run(2);
        cmd = 1'b1; run(TD);
        tag = "R7";
        run(8);
        cmd = 1'b0; run(2);
        cmd = 1'b1; run(TP + 3);

        // R8: enable high during full drive, undervoltage during plateau and fault
        tag = "R8";
        en_n = 1'b1; run(3);
        en_n = 1'b0; run(TP + BX + 2);
        cmd = 1'b0; run(1); cmd = 1'b1; run(2);
        uv = 1'b1; run(2); uv = 1'b0; run(TP + BX + 2);
        desat = 1'b1; run(4); desat = 1'b0;
        uv = 1'b1; run(2); uv = 1'b0; run(3);

        // R9: command falls during plateau and during fault time
        tag = "R9";
        cmd = 1'b0; run(1);
        cmd = 1'b1; run(2);
        cmd = 1'b0; run(2);
        cmd = 1'b1; run(TP + BX + 2);
        desat = 1'b1; run(4);
        cmd = 1'b0; desat = 1'b0; run(4);

        // R10: constrained random traffic, drive codes and reply checked each cycle
        tag = "R10";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 19) == 0) cmd = ~cmd;
            if ($urandom_range(0, 7) == 0) desat = ~desat;
            if ($urandom_range(0, 149) == 0) en_n = ~en_n;
            uv = ($urandom_range(0, 299) == 0);
            tick();
            if (drive === 2'b11) begin
                errors++;
                $display("FAIL R10 drive=%b expected not 11", drive);
            end
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule